// File: doc/BRIEF.md
# Scalar Load/Store Address Generator

This unit produces the 32-bit value that a scalar memory operation needs: either the effective address for a load or store, or a plain result for the two modes that never touch memory. Each cycle the issuing logic may present one operation: a mode code, a store/load flag, a base register value, an index register value, a 2-bit scale code and a 21-bit immediate field. The base can be replaced by the program counter, so any memory mode can be PC-relative.

Four modes are supported. The first adds a signed 14-bit offset to the base. The second adds an index scaled by 1, 2, 4 or 8. The third loads a constant, either the sign-extended 21-bit immediate or that immediate moved up by 11 bits with the low 11 bits all zeros or all ones. The fourth computes base plus scaled index and returns it as data. The last two are meaningful for loads only. A store that requests either of them is flagged as illegal and produces no valid output.

The result is registered. An accepted operation appears on the outputs one clock later, with a flag telling downstream logic whether memory must be accessed.

Top module: `scalar_agu`

## Requirements
- R1: After reset is asserted, result_o is 0 and valid_o, mem_o and illegal_o are 0.
- R2: With mode_i = 2'b00 (base plus offset), result_o = base + sign-extended imm_i[13:0] and mem_o = 1. Bits imm_i[20:14] have no effect in this mode.
- R3: With mode_i = 2'b01 (base plus scaled index), result_o = base + index × 2^scale_i, where scale_i 0,1,2,3 gives factors 1,2,4,8, and mem_o = 1.
- R4: With mode_i = 2'b10 (constant load) and imm_shift_i = 0, result_o is imm_i sign-extended from bit 20, and mem_o = 0.
- R5: With mode_i = 2'b10 and imm_shift_i = 1, result_o = {imm_i, eleven copies of imm_fill_i}.
- R6: With mode_i = 2'b11 (address as data), result_o = base + index × 2^scale_i, and mem_o = 0.
- R7: When use_pc_i = 1, pc_i replaces base_i as the base operand in modes 2'b00, 2'b01 and 2'b11.
- R8: All sums wrap modulo 2^32.
- R9: A valid store (store_i = 1) in mode 2'b10 or 2'b11 sets illegal_o = 1 and valid_o = 0 and mem_o = 0 in the next cycle, and result_o keeps its previous value.
- R10: An accepted operation (valid_i = 1 and not illegal) drives valid_o = 1 and the new result_o exactly one cycle later; a cycle with valid_i = 0 gives valid_o = mem_o = illegal_o = 0 next cycle and leaves result_o unchanged.
- R11: Stores in modes 2'b00 and 2'b01 are legal and give valid_o = 1 with mem_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| store_i | input | 1 | 1 for a store, 0 for a load |
| mode_i | input | 2 | 00 base+offset, 01 base+scaled index, 10 constant, 11 address as data |
| use_pc_i | input | 1 | Select pc_i as the base operand |
| base_i | input | 32 | Base register value |
| pc_i | input | 32 | Program counter value |
| index_i | input | 32 | Index register value |
| scale_i | input | 2 | Index shift amount 0..3 |
| imm_i | input | 21 | Immediate field |
| imm_shift_i | input | 1 | Move the constant up by 11 bits |
| imm_fill_i | input | 1 | Fill value for the vacated low 11 bits |
| result_o | output | 32 | Registered address or data |
| valid_o | output | 1 | result_o holds a new accepted result |
| mem_o | output | 1 | Result is an address for a memory access |
| illegal_o | output | 1 | Previous cycle carried a store in a load-only mode |

## Verification
The two functions that can meet in one cycle are the illegal-store rejection and the holding of the result register: a rejected store arrives on the edge right after a legal operation has loaded a fresh result. The bench issues a legal address calculation and, on the very next cycle, a store in a load-only mode whose operands would produce a different value. It judges that illegal_o rises, valid_o and mem_o fall, and result_o still shows the earlier value rather than the rejected operation's sum.

// File: rtl/scalar_agu_pkg.sv
package scalar_agu_pkg;
  typedef enum logic [1:0] {
    AGU_BASE_OFF = 2'b00,
    AGU_BASE_IDX = 2'b01,
    AGU_CONST    = 2'b10,
    AGU_ADDR_DAT = 2'b11
  } agu_mode_e;

  function automatic logic mode_is_mem(agu_mode_e m);
    return (m == AGU_BASE_OFF) || (m == AGU_BASE_IDX);
  endfunction
endpackage

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic [DATA_W-1:0]  index_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [DATA_W-1:0]  scaled_o
);
  localparam int NUM_SCALES = 1 << SCALE_W;

  logic [DATA_W-1:0] cand [NUM_SCALES];

  for (genvar s = 0; s < NUM_SCALES; s++) begin : g_cand
    assign cand[s] = index_i << s;
  end

  assign scaled_o = cand[scale_i];
endmodule

// File: rtl/agu_const_expand.sv
module agu_const_expand #(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 21,
  parameter int SHIFT_AMT = 11
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              shift_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] value_o
);
  localparam int WIDE_W = IMM_W + SHIFT_AMT;

  logic [DATA_W-1:0] sext_val;
  logic [DATA_W-1:0] high_val;
  logic [WIDE_W-1:0] wide_val;

  assign sext_val = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign wide_val = {imm_i, {SHIFT_AMT{fill_i}}};

  if (WIDE_W >= DATA_W) begin : g_trunc
    assign high_val = wide_val[DATA_W-1:0];
  end else begin : g_ext
    assign high_val = {{(DATA_W-WIDE_W){imm_i[IMM_W-1]}}, wide_val};
  end

  assign value_o = shift_i ? high_val : sext_val;
endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              mem_i,
  input  logic              illegal_i,
  input  logic [DATA_W-1:0] value_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              mem_o,
  output logic              illegal_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      valid_o   <= 1'b0;
      mem_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= accept_i;
      mem_o     <= accept_i & mem_i;
      illegal_o <= illegal_i;
      if (accept_i) result_o <= value_i;
    end
  end
endmodule

// File: rtl/scalar_agu.sv
module scalar_agu
  import scalar_agu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 14,
  parameter int IMM_W     = 21,
  parameter int SHIFT_AMT = 11,
  parameter int SCALE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              store_i,
  input  logic [1:0]        mode_i,
  input  logic              use_pc_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] index_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_shift_i,
  input  logic              imm_fill_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              mem_o,
  output logic              illegal_o
);
  localparam int OFF_PAD = DATA_W - OFF_W;

  agu_mode_e         mode;
  logic [DATA_W-1:0] base_sel;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] scaled;
  logic [DATA_W-1:0] const_val;
  logic [DATA_W-1:0] value;
  logic              is_mem;
  logic              illegal;
  logic              accept;

  assign mode     = agu_mode_e'(mode_i);
  assign base_sel = use_pc_i ? pc_i : base_i;
  assign offset   = {{OFF_PAD{imm_i[OFF_W-1]}}, imm_i[OFF_W-1:0]};

  agu_index_scale #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_scale (
    .index_i  (index_i),
    .scale_i  (scale_i),
    .scaled_o (scaled)
  );

  agu_const_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHIFT_AMT(SHIFT_AMT)) u_const (
    .imm_i   (imm_i),
    .shift_i (imm_shift_i),
    .fill_i  (imm_fill_i),
    .value_o (const_val)
  );

  always_comb begin
    unique case (mode)
      AGU_BASE_OFF: value = base_sel + offset;
      AGU_CONST:    value = const_val;
      default:      value = base_sel + scaled;  // scaled index and address-as-data
    endcase
  end

  assign is_mem  = mode_is_mem(mode);
  // load-only modes reject stores
  assign illegal = valid_i & store_i & ~is_mem;
  assign accept  = valid_i & ~illegal;

  agu_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .mem_i     (is_mem),
    .illegal_i (illegal),
    .value_i   (value),
    .result_o  (result_o),
    .valid_o   (valid_o),
    .mem_o     (mem_o),
    .illegal_o (illegal_o)
  );
endmodule

// File: rtl/scalar_agu_chk.sv
module scalar_agu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              store_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic              mem_o,
  input logic              illegal_o
);
  // R9
  illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!valid_o && !mem_o));

  // R9
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && store_i && mode_i[1]) |=> (illegal_o && $stable(result_o)));

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !mem_o && !illegal_o && $stable(result_o)));

  // R10
  mem_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_o |-> valid_o);

  // R11
  store_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && store_i && !mode_i[1]) |=> (valid_o && mem_o));

  // R4
  no_mem_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !store_i && mode_i[1]) |=> (valid_o && !mem_o));
endmodule

bind scalar_agu scalar_agu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .store_i   (store_i),
  .mode_i    (mode_i),
  .result_o  (result_o),
  .valid_o   (valid_o),
  .mem_o     (mem_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_scalar_agu.sv
`timescale 1ns/1ps
module sim_scalar_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        store_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        use_pc_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] index_i = '0;
  logic [1:0]  scale_i = '0;
  logic [20:0] imm_i = '0;
  logic        imm_shift_i = 1'b0;
  logic        imm_fill_i = 1'b0;
  logic [31:0] result_o;
  logic        valid_o, mem_o, illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  scalar_agu u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .store_i(store_i),
    .mode_i(mode_i), .use_pc_i(use_pc_i), .base_i(base_i), .pc_i(pc_i),
    .index_i(index_i), .scale_i(scale_i), .imm_i(imm_i),
    .imm_shift_i(imm_shift_i), .imm_fill_i(imm_fill_i),
    .result_o(result_o), .valid_o(valid_o), .mem_o(mem_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one op at negedge, sample after the next rising edge
  task automatic issue(input logic st, input logic [1:0] md, input logic pc_sel,
                       input logic [31:0] b, input logic [31:0] p, input logic [31:0] ix,
                       input logic [1:0] sc, input logic [20:0] im,
                       input logic sh, input logic fl);
    @(negedge clk_i);
    valid_i = 1'b1; store_i = st; mode_i = md; use_pc_i = pc_sel;
    base_i = b; pc_i = p; index_i = ix; scale_i = sc; imm_i = im;
    imm_shift_i = sh; imm_fill_i = fl;
    @(posedge clk_i); #5;
    valid_i = 1'b0;
  endtask

  function automatic logic [31:0] sx14(input logic [13:0] v);
    return {{18{v[13]}}, v};
  endfunction

  task automatic t_reset();
    chk("R1 result", result_o, 32'h0);
    chk("R1 valid", {31'b0, valid_o}, 32'h0);
    chk("R1 mem", {31'b0, mem_o}, 32'h0);
    chk("R1 illegal", {31'b0, illegal_o}, 32'h0);
  endtask

  task automatic t_base_off();
    issue(0, 2'b00, 0, 32'h0000_1000, 32'h0, 32'h0, 2'd0, {7'h55, 14'h3FFF}, 0, 0);
    chk("R2 neg offset, high imm bits ignored", result_o, 32'h0000_0FFF);
    chk("R2 mem", {31'b0, mem_o}, 32'h1);
    issue(0, 2'b00, 0, 32'h0000_1000, 32'h0, 32'h0, 2'd0, {7'h00, 14'h1FFF}, 0, 0);
    chk("R2 max positive offset", result_o, 32'h0000_1000 + 32'd8191);
    issue(0, 2'b00, 0, 32'h0000_4000, 32'h0, 32'h0, 2'd0, {7'h7F, 14'h2000}, 0, 0);
    chk("R2 min negative offset", result_o, 32'h0000_4000 + sx14(14'h2000));
  endtask

  task automatic t_base_idx();
    for (int s = 0; s < 4; s++) begin
      issue(0, 2'b01, 0, 32'h1000_0000, 32'h0, 32'h0000_0123, s[1:0], '0, 0, 0);
      chk($sformatf("R3 scale code %0d", s), result_o, 32'h1000_0000 + 32'h123 * (32'd1 << s));
      chk("R3 mem", {31'b0, mem_o}, 32'h1);
    end
  endtask

  task automatic t_const();
    issue(0, 2'b10, 0, 32'hDEAD_BEEF, 32'h0, 32'h0, 2'd0, 21'h100000, 0, 0);
    chk("R4 sign-extended constant", result_o, 32'hFFF0_0000);
    chk("R4 no memory", {31'b0, mem_o}, 32'h0);
    issue(0, 2'b10, 0, 32'h0, 32'h0, 32'h0, 2'd0, 21'h0ABCD, 0, 1);
    chk("R4 positive constant, fill unused", result_o, 32'h0000_ABCD);
    issue(0, 2'b10, 0, 32'h0, 32'h0, 32'h0, 2'd0, 21'h12345, 1, 0);
    chk("R5 shifted zero fill", result_o, 32'h1234_5000 >> 1 << 0 == 32'h0 ? 32'h0 : (32'h12345 << 11));
    issue(0, 2'b10, 0, 32'h0, 32'h0, 32'h0, 2'd0, 21'h12345, 1, 1);
    chk("R5 shifted one fill", result_o, (32'h12345 << 11) | 32'h7FF);
  endtask

  task automatic t_addr_dat();
    issue(0, 2'b11, 0, 32'h0000_2000, 32'h0, 32'h0000_0010, 2'd3, '0, 0, 0);
    chk("R6 value", result_o, 32'h0000_2080);
    chk("R6 no memory", {31'b0, mem_o}, 32'h0);
    chk("R6 valid", {31'b0, valid_o}, 32'h1);
  endtask

  task automatic t_pc();
    issue(0, 2'b00, 1, 32'h5555_0000, 32'h0040_0000, 32'h0, 2'd0, 21'h00010, 0, 0);
    chk("R7 pc base offset", result_o, 32'h0040_0010);
    issue(1, 2'b01, 1, 32'h5555_0000, 32'h0040_0000, 32'h4, 2'd2, '0, 0, 0);
    chk("R7 pc base scaled index", result_o, 32'h0040_0010);
    issue(0, 2'b11, 1, 32'h5555_0000, 32'h0040_0000, 32'h1, 2'd0, '0, 0, 0);
    chk("R7 pc base address data", result_o, 32'h0040_0001);
  endtask

  task automatic t_wrap();
    issue(0, 2'b01, 0, 32'hFFFF_FFF0, 32'h0, 32'h0000_0004, 2'd3, '0, 0, 0);
    chk("R8 wrap scaled", result_o, 32'h0000_0010);
    issue(0, 2'b00, 0, 32'h0000_0004, 32'h0, 32'h0, 2'd0, 21'h03FF0, 0, 0);
    chk("R8 wrap below zero", result_o, 32'hFFFF_FFF4);
  endtask

  task automatic t_illegal();
    // legal op, then a rejected store the very next cycle
    issue(0, 2'b11, 0, 32'h0000_0100, 32'h0, 32'h1, 2'd0, '0, 0, 0);
    chk("R9 setup", result_o, 32'h0000_0101);
    issue(1, 2'b11, 0, 32'h0000_9000, 32'h0, 32'h7, 2'd1, '0, 0, 0);
    chk("R9 illegal flag", {31'b0, illegal_o}, 32'h1);
    chk("R9 no valid", {31'b0, valid_o}, 32'h0);
    chk("R9 no mem", {31'b0, mem_o}, 32'h0);
    chk("R9 result held", result_o, 32'h0000_0101);
    issue(1, 2'b10, 0, 32'h0, 32'h0, 32'h0, 2'd0, 21'h00077, 0, 0);
    chk("R9 constant store illegal", {31'b0, illegal_o}, 32'h1);
    chk("R9 result held after constant store", result_o, 32'h0000_0101);
  endtask

  task automatic t_idle_latency();
    issue(0, 2'b00, 0, 32'h0000_0A00, 32'h0, 32'h0, 2'd0, 21'h00005, 0, 0);
    chk("R10 one-cycle result", result_o, 32'h0000_0A05);
    chk("R10 valid", {31'b0, valid_o}, 32'h1);
    base_i = 32'hFFFF_0000;
    @(posedge clk_i); #5;
    chk("R10 idle valid low", {31'b0, valid_o}, 32'h0);
    chk("R10 idle mem low", {31'b0, mem_o}, 32'h0);
    chk("R10 idle result held", result_o, 32'h0000_0A05);
  endtask

  task automatic t_store_ok();
    issue(1, 2'b00, 0, 32'h0000_3000, 32'h0, 32'h0, 2'd0, 21'h00008, 0, 0);
    chk("R11 store valid", {31'b0, valid_o}, 32'h1);
    chk("R11 store mem", {31'b0, mem_o}, 32'h1);
    chk("R11 store illegal low", {31'b0, illegal_o}, 32'h0);
    chk("R11 store address", result_o, 32'h0000_3008);
  endtask

  initial begin
    #45;
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_base_off();
    t_base_idx();
    t_const();
    t_addr_dat();
    t_pc();
    t_wrap();
    t_illegal();
    t_idle_latency();
    t_store_ok();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule